// File: doc/BRIEF.md
# Protection CSR Write Controller

This block holds the control state of a physical memory protection unit: one configuration byte and one address register for each of sixteen entries, plus a three-bit security configuration register. Software reaches it through a single-cycle write port that names a register by a select code and carries 32 bits of data. Before any write lands, the block checks it against the entry lock bits, the rule-locking bypass bit and the reserved permission encodings. A write that breaks a rule changes nothing and raises a one-cycle error flag. A write that passes updates the named register on the same clock edge.

The current contents of every register can be read at any time through a combinational readback port that uses the same select codes. The block does not perform the access check against these entries. It also does not reinterpret permissions when lockdown mode is set.

Top module: `pmp_csr_ctrl`

## Requirements
- R1: After reset every configuration byte and every address register reads 0, the security register reads 0x4 (bypass set, other bits clear), and `err_o` is low.
- R2: Select codes 0 to 3 address the packed configuration registers, with entry 4k+i in bits [8i+7:8i] of register k. Codes 16 to 31 address the address register of entry code-16. Code 32 addresses the security register. Any other code reads as 0, and a write to it is rejected.
- R3: The configuration byte layout is: bit 0 read, bit 1 write, bit 2 execute, bits 4:3 match mode (0 off, 1 top-of-range, 2 four-byte, 3 power-of-two), bit 7 lock. Written values of bits 6:5 are dropped, and those bits always read 0.
- R4: Security register bit 0 is lockdown, bit 1 is whitelist policy and bit 2 is bypass. Bits 31:3 read 0. Bits 0 and 1 take any written value.
- R5: While lockdown is clear, a configuration write in which any byte has write=1 and read=0 is rejected as a whole. While lockdown is set, the same write is accepted.
- R6: While bypass is clear, a configuration write that would change a locked entry's byte (after bits 6:5 are dropped) is rejected as a whole. A write that leaves the locked byte equal to its current value is accepted, so the unlocked neighbours in the same register can still change.
- R7: While bypass is clear, a write to the address register of a locked entry is rejected. While bypass is set, it is accepted.
- R8: While bypass is clear, a write to the address register of entry e is rejected when entry e+1 is locked and in top-of-range mode.
- R9: Bypass may always be cleared. Setting it when it is clear is rejected if any entry is locked, and accepted if no entry is locked.
- R10: An accepted write updates its register on the clock edge that samples it, and `err_o` stays low. A rejected write changes no register, and `err_o` is high for exactly the cycle after that edge.
- R11: An address register stores all 32 written bits as a word address and reads them back unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en_i | input | 1 | Write request for this cycle |
| wr_sel_i | input | SEL_W (6) | Register select for the write |
| wr_data_i | input | DATA_W (32) | Write data |
| err_o | output | 1 | High in the cycle after a rejected write |
| rd_sel_i | input | SEL_W (6) | Register select for readback |
| rd_data_o | output | DATA_W (32) | Current value of the selected register |

## Verification
The hardest situation to reach is a locked entry while bypass is clear. Once a lock is in place with bypass clear, the block can never leave that state without a reset. The stimulus therefore runs every bypass-free and unlock-dependent case first: re-arming bypass with no locks, and the lockdown-dependent reserved check. Only then does it lock entry 6 in top-of-range mode and clear bypass. From that point it probes the four guards in turn: setting bypass again, the locked entry's own address, the guarded neighbour address below it, and a configuration write that rewrites the locked byte unchanged (including with bits 6:5 set) while it edits the neighbours.

// File: rtl/pmp_csr_pkg.sv
// Shared definitions for the protection CSR write controller.
// Assumes configuration bytes are 8 bits wide and that the security register holds three bits.
package pmp_csr_pkg;

    localparam int unsigned CFG_BYTE_W   = 8;
    localparam int unsigned SEC_W        = 3;
    localparam int unsigned SEC_LOCKDOWN = 0;
    localparam int unsigned SEC_POLICY   = 1;
    localparam int unsigned SEC_BYPASS   = 2;
    localparam logic [SEC_W-1:0] SEC_RESET = 3'b100;

    typedef enum logic [1:0] {
        MODE_OFF   = 2'd0,
        MODE_TOR   = 2'd1,
        MODE_NA4   = 2'd2,
        MODE_NAPOT = 2'd3
    } match_mode_e;

    typedef struct packed {
        logic        lock;
        logic [1:0]  gap;
        match_mode_e mode;
        logic        x;
        logic        w;
        logic        r;
    } cfg_byte_t;

    // Drop the always-zero field from a raw byte.
    function automatic cfg_byte_t sanitize_cfg(input logic [CFG_BYTE_W-1:0] raw);
        cfg_byte_t b;
        b     = cfg_byte_t'(raw);
        b.gap = 2'b00;
        return b;
    endfunction

    // Write without read is reserved unless lockdown is active.
    function automatic logic is_reserved_perm(input cfg_byte_t b, input logic lockdown);
        return !lockdown && b.w && !b.r;
    endfunction

endpackage

// File: rtl/pmp_cfg_bank.sv
// Storage for the per-entry configuration bytes.
// Assumes the write enables arrive already filtered by the judge; it stores without further checks.
module pmp_cfg_bank #(
    parameter int unsigned NUM_ENTRIES = 16
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic [NUM_ENTRIES-1:0]                   we_i,
    input  pmp_csr_pkg::cfg_byte_t [NUM_ENTRIES-1:0] wdata_i,
    output pmp_csr_pkg::cfg_byte_t [NUM_ENTRIES-1:0] cfg_q_o
);

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_entry
        // Hold one configuration byte; reset to off and unlocked.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_q_o[g] <= '0;
            end else if (we_i[g]) begin
                cfg_q_o[g] <= wdata_i[g];
            end
        end
    end

endmodule

// File: rtl/pmp_addr_bank.sv
// Storage for the per-entry word-address registers.
// Assumes at most one enable is high per cycle; all share the same write data.
module pmp_addr_bank #(
    parameter int unsigned NUM_ENTRIES = 16,
    parameter int unsigned DATA_W      = 32
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [NUM_ENTRIES-1:0]             we_i,
    input  logic [DATA_W-1:0]                  wdata_i,
    output logic [NUM_ENTRIES-1:0][DATA_W-1:0] addr_q_o
);

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_entry
        // Hold one word address; reset to zero.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                addr_q_o[g] <= '0;
            end else if (we_i[g]) begin
                addr_q_o[g] <= wdata_i;
            end
        end
    end

endmodule

// File: rtl/pmp_write_judge.sv
// Decodes a write request and decides whether it may land.
// Purely combinational. Assumes DATA_W is a multiple of 8 and NUM_ENTRIES a multiple of the
// bytes per configuration register. The enables it returns are already cleared on rejection.
module pmp_write_judge #(
    parameter int unsigned NUM_ENTRIES = 16,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned SEL_W       = 6
) (
    input  logic                                     wr_en_i,
    input  logic [SEL_W-1:0]                         wr_sel_i,
    input  logic [DATA_W-1:0]                        wr_data_i,
    input  pmp_csr_pkg::cfg_byte_t [NUM_ENTRIES-1:0] cfg_q_i,
    input  logic                                     lockdown_i,
    input  logic                                     bypass_i,
    output logic [NUM_ENTRIES-1:0]                   cfg_we_o,
    output pmp_csr_pkg::cfg_byte_t [NUM_ENTRIES-1:0] cfg_wdata_o,
    output logic [NUM_ENTRIES-1:0]                   addr_we_o,
    output logic                                     sec_we_o,
    output logic                                     reject_o
);
    import pmp_csr_pkg::*;

    localparam int PER_REG  = DATA_W / CFG_BYTE_W;
    localparam int CFG_REGS = NUM_ENTRIES / PER_REG;
    localparam int ADDR_LO  = NUM_ENTRIES;
    localparam int SEC_SEL  = 2 * NUM_ENTRIES;

    int                     sel;
    logic                   hit_cfg, hit_addr, hit_sec;
    logic                   cfg_bad, addr_bad, sec_bad, any_locked, accept;
    logic [NUM_ENTRIES-1:0] tor_guard;

    assign sel      = int'(wr_sel_i);
    assign hit_cfg  = sel < CFG_REGS;
    assign hit_addr = (sel >= ADDR_LO) && (sel < SEC_SEL);
    assign hit_sec  = sel == SEC_SEL;

    // Mark entries whose address is pinned by a locked top-of-range successor.
    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_guard
        if (g < NUM_ENTRIES - 1) begin : g_inner
            assign tor_guard[g] = cfg_q_i[g+1].lock && (cfg_q_i[g+1].mode == MODE_TOR);
        end else begin : g_last
            assign tor_guard[g] = 1'b0;
        end
    end

    // Evaluate every rule for the addressed register.
    always_comb begin
        cfg_we_o    = '0;
        addr_we_o   = '0;
        cfg_wdata_o = '0;
        cfg_bad     = 1'b0;
        addr_bad    = 1'b0;
        any_locked  = 1'b0;
        for (int e = 0; e < NUM_ENTRIES; e++) begin
            any_locked     = any_locked | cfg_q_i[e].lock;
            cfg_wdata_o[e] = sanitize_cfg(wr_data_i[CFG_BYTE_W*(e%PER_REG) +: CFG_BYTE_W]);
            if (hit_cfg && (e / PER_REG) == sel) begin
                cfg_we_o[e] = 1'b1;
                if (is_reserved_perm(cfg_wdata_o[e], lockdown_i)) cfg_bad = 1'b1;
                if (cfg_q_i[e].lock && !bypass_i && (cfg_wdata_o[e] != cfg_q_i[e])) cfg_bad = 1'b1;
            end
            if (hit_addr && (e + ADDR_LO) == sel) begin
                addr_we_o[e] = 1'b1;
                if (!bypass_i && (cfg_q_i[e].lock || tor_guard[e])) addr_bad = 1'b1;
            end
        end
        sec_bad  = hit_sec && wr_data_i[SEC_BYPASS] && !bypass_i && any_locked;
        reject_o = wr_en_i && (cfg_bad || addr_bad || sec_bad || !(hit_cfg || hit_addr || hit_sec));
        accept   = wr_en_i && !reject_o;
        sec_we_o = accept && hit_sec;
        if (!accept) begin
            cfg_we_o  = '0;
            addr_we_o = '0;
        end
    end

endmodule

// File: rtl/pmp_csr_ctrl.sv
// Protection CSR write controller: owns the entry configuration bytes, the address registers and
// the security register, filters writes through the judge and offers combinational readback.
// Assumes a single write per cycle and a synchronous active-low reset.
module pmp_csr_ctrl #(
    parameter int unsigned NUM_ENTRIES = 16,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned SEL_W       = $clog2(NUM_ENTRIES) + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [SEL_W-1:0]  wr_sel_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic              err_o,
    input  logic [SEL_W-1:0]  rd_sel_i,
    output logic [DATA_W-1:0] rd_data_o
);
    import pmp_csr_pkg::*;

    localparam int PER_REG  = DATA_W / CFG_BYTE_W;
    localparam int CFG_REGS = NUM_ENTRIES / PER_REG;
    localparam int SEC_SEL  = 2 * NUM_ENTRIES;

    cfg_byte_t [NUM_ENTRIES-1:0]             cfg_q, cfg_wdata;
    logic      [NUM_ENTRIES-1:0][DATA_W-1:0] addr_q;
    logic      [NUM_ENTRIES-1:0]             cfg_we, addr_we;
    logic      [SEC_W-1:0]                   sec_q;
    logic                                    sec_we, reject, err_q, locked_seen;
    int                                      rsel;

    pmp_write_judge #(.NUM_ENTRIES(NUM_ENTRIES), .DATA_W(DATA_W), .SEL_W(SEL_W)) u_judge (
        .wr_en_i    (wr_en_i),
        .wr_sel_i   (wr_sel_i),
        .wr_data_i  (wr_data_i),
        .cfg_q_i    (cfg_q),
        .lockdown_i (sec_q[SEC_LOCKDOWN]),
        .bypass_i   (sec_q[SEC_BYPASS]),
        .cfg_we_o   (cfg_we),
        .cfg_wdata_o(cfg_wdata),
        .addr_we_o  (addr_we),
        .sec_we_o   (sec_we),
        .reject_o   (reject)
    );

    pmp_cfg_bank #(.NUM_ENTRIES(NUM_ENTRIES)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (cfg_we),
        .wdata_i(cfg_wdata),
        .cfg_q_o(cfg_q)
    );

    pmp_addr_bank #(.NUM_ENTRIES(NUM_ENTRIES), .DATA_W(DATA_W)) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (addr_we),
        .wdata_i (wr_data_i),
        .addr_q_o(addr_q)
    );

    // Security register: reset with bypass set, loaded on accepted writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_q <= SEC_RESET;
        end else if (sec_we) begin
            sec_q <= wr_data_i[SEC_W-1:0];
        end
    end

    // Error flag: registered copy of this cycle's rejection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else begin
            err_q <= reject;
        end
    end

    assign err_o = err_q;
    assign rsel  = int'(rd_sel_i);

    // Readback multiplexer over every register.
    always_comb begin
        rd_data_o = '0;
        for (int e = 0; e < NUM_ENTRIES; e++) begin
            if (rsel < CFG_REGS && (e / PER_REG) == rsel)
                rd_data_o[CFG_BYTE_W*(e%PER_REG) +: CFG_BYTE_W] = cfg_q[e];
            if (rsel == e + NUM_ENTRIES) rd_data_o = addr_q[e];
        end
        if (rsel == SEC_SEL) rd_data_o[SEC_W-1:0] = sec_q;
    end

    // Independent view of whether any entry is locked, used by the checks below.
    always_comb begin
        locked_seen = 1'b0;
        for (int e = 0; e < NUM_ENTRIES; e++) locked_seen = locked_seen | cfg_q[e].lock;
    end

    assert_reject_keeps_state_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> ($stable(cfg_q) && $stable(addr_q) && $stable(sec_q)));

    assert_err_follows_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> $past(wr_en_i));

    assert_bypass_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!sec_q[SEC_BYPASS] && locked_seen) |=> !sec_q[SEC_BYPASS]);

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_chk
        assert_locked_cfg_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_q[g].lock && !sec_q[SEC_BYPASS]) |=> $stable(cfg_q[g]));

        assert_locked_addr_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_q[g].lock && !sec_q[SEC_BYPASS]) |=> $stable(addr_q[g]));

        assert_no_reserved_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we[g] && !sec_q[SEC_LOCKDOWN]) |-> !(cfg_wdata[g].w && !cfg_wdata[g].r));

        if (g < NUM_ENTRIES - 1) begin : g_tor
            assert_tor_guard_R8: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_q[g+1].lock && cfg_q[g+1].mode == MODE_TOR && !sec_q[SEC_BYPASS])
                |=> $stable(addr_q[g]));
        end
    end

endmodule

// File: tb/tb_pmp_csr_ctrl.sv
// Scoreboard bench: driver tasks queue expected values, a monitor pops and compares them.
module tb_pmp_csr_ctrl;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [5:0]  wr_sel;
    logic [31:0] wr_data;
    logic        err_o;
    logic [5:0]  rd_sel;
    logic [31:0] rd_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    int          q_kind[$];
    int          q_sel[$];
    logic [31:0] q_exp[$];
    string       q_tag[$];
    event        ev_check;

    always #4 clk = ~clk;

    pmp_csr_ctrl dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (wr_en),
        .wr_sel_i (wr_sel),
        .wr_data_i(wr_data),
        .err_o    (err_o),
        .rd_sel_i (rd_sel),
        .rd_data_o(rd_data)
    );

    // Monitor: compare queued expectations with what the design shows.
    initial begin
        forever begin
            @(ev_check);
            while (q_kind.size() > 0) begin
                automatic int          kind = q_kind.pop_front();
                automatic int          sel  = q_sel.pop_front();
                automatic logic [31:0] exp  = q_exp.pop_front();
                automatic string       tag  = q_tag.pop_front();
                automatic logic [31:0] act  = (kind == 0) ? {31'b0, err_o} : rd_data;
                checks++;
                if (act !== exp) begin
                    fails++;
                    $display("FAIL %s: %s sel %0d actual 0x%08h expected 0x%08h",
                             tag, (kind == 0) ? "err" : "read", sel, act, exp);
                end
            end
        end
    end

    task automatic push_item(input int kind, input int sel, input logic [31:0] exp, input string tag);
        if (kind == 1) rd_sel = sel[5:0];
        q_kind.push_back(kind);
        q_sel.push_back(sel);
        q_exp.push_back(exp);
        q_tag.push_back(tag);
        #1;
        ->ev_check;
        #1;
    endtask

    task automatic wr(input int sel, input logic [31:0] data, input logic exp_err, input string tag);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_sel  = sel[5:0];
        wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
        push_item(0, sel, {31'b0, exp_err}, tag);
    endtask

    task automatic rd(input int sel, input logic [31:0] exp, input string tag);
        push_item(1, sel, exp, tag);
    endtask

    task automatic err_idle(input string tag);
        @(negedge clk);
        push_item(0, 0, 32'h0, tag);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    // Driver: stimulus and expectations.
    initial begin
        rst_n   = 1'b0;
        wr_en   = 1'b0;
        wr_sel  = '0;
        wr_data = '0;
        rd_sel  = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        push_item(0, 0, 32'h0, "R1");
        for (int k = 0; k < 4; k++) rd(k, 32'h0, "R1");
        for (int a = 16; a < 32; a++) rd(a, 32'h0, "R1");
        rd(32, 32'h4, "R1");

        // R3 packing and dropped gap bits
        wr(0, 32'h001C6D0B, 1'b0, "R3");
        rd(0, 32'h001C0D0B, "R3");

        // R5 reserved encoding rejected with lockdown clear; R10 single-cycle error
        wr(1, 32'h00000002, 1'b1, "R5");
        rd(1, 32'h0, "R5");
        err_idle("R10");

        // R9 bypass clear and re-set while nothing is locked
        wr(32, 32'h0, 1'b0, "R9");
        rd(32, 32'h0, "R9");
        wr(32, 32'h4, 1'b0, "R9");
        rd(32, 32'h4, "R9");

        // R4 upper bits dropped; R5 reserved accepted under lockdown
        wr(32, 32'hFFFFFFF5, 1'b0, "R4");
        rd(32, 32'h5, "R4");
        wr(1, 32'h00000002, 1'b0, "R5");
        rd(1, 32'h00000002, "R5");
        wr(32, 32'h6, 1'b0, "R4");
        rd(32, 32'h6, "R4");

        // R11 full-width address storage
        wr(21, 32'hDEADBEEF, 1'b0, "R11");
        rd(21, 32'hDEADBEEF, "R11");

        // Lock entry 6 in top-of-range mode while bypass is set
        wr(1, 32'h00890001, 1'b0, "R6");
        rd(1, 32'h00890001, "R6");
        wr(22, 32'h00000100, 1'b0, "R7");
        rd(22, 32'h00000100, "R7");
        wr(21, 32'h00000080, 1'b0, "R8");
        rd(21, 32'h00000080, "R8");

        // Clear bypass, then try to re-set it
        wr(32, 32'h2, 1'b0, "R9");
        rd(32, 32'h2, "R9");
        wr(32, 32'h6, 1'b1, "R9");
        rd(32, 32'h2, "R9");

        // R7 locked entry address frozen
        wr(22, 32'h00000200, 1'b1, "R7");
        rd(22, 32'h00000100, "R7");

        // R8 address below locked top-of-range entry frozen
        wr(21, 32'h00000300, 1'b1, "R8");
        rd(21, 32'h00000080, "R8");

        // Unaffected neighbours still writable
        wr(20, 32'h00000044, 1'b0, "R8");
        rd(20, 32'h00000044, "R8");
        wr(23, 32'h00000077, 1'b0, "R7");
        rd(23, 32'h00000077, "R7");

        // R6 changing a locked byte rejected; rewriting it unchanged accepted
        wr(1, 32'h00880001, 1'b1, "R6");
        rd(1, 32'h00890001, "R6");
        wr(1, 32'h1B890405, 1'b0, "R6");
        rd(1, 32'h1B890405, "R6");
        wr(1, 32'h1BE90405, 1'b0, "R3");
        rd(1, 32'h1B890405, "R3");

        // R2 unmapped select codes
        wr(33, 32'hFFFFFFFF, 1'b1, "R2");
        rd(33, 32'h0, "R2");
        rd(4, 32'h0, "R2");
        err_idle("R10");

        done = 1'b1;
        summary();
        $finish;
    end

endmodule